// File: doc/BRIEF.md
# Idle-Triggered Bus Clock Throttle

This block turns a base clock-enable pulse stream into the clock-enable used by a system bus domain. While any client of the domain reports activity, every base pulse is passed on, so the domain runs at its full rate. Once all clients are quiet, the block passes on only one base pulse out of every D. D is a programmable extra-divide value. This lowers the switching activity of an idle domain and so saves power.

The throttle can be turned off with an enable input. It is also held off while the external memory clock runs synchronously with the bus clock, because the memory cannot tolerate a rate that changes. Rate changes are made only at the edge of a divided period, so a slow interval is never cut short. A status output tells the rest of the system whether the reduced rate is in effect.

Top module: `bus_idle_throttle`

## Requirements
- R1: While the throttle cannot act, each base pulse (`base_ce` high for one clock) yields `bus_ce` high in the next clock cycle. The throttle cannot act when `thr_enable` is 0, when `mem_sync` is 1, when any `busy` bit is 1, or when `extra_div` is below 2.
- R2: In full-rate mode, a base pulse that sees the throttle allowed still produces its `bus_ce`. `slow_active` then reads 1 from the next cycle on.
- R3: While in reduced mode, `bus_ce` is produced for exactly one base pulse out of every D, where D is the `extra_div` value latched at the last period boundary. No other base pulse produces `bus_ce`.
- R4: A change of `extra_div` made during a reduced period does not alter that period. The new value is latched only at the base pulse that ends the period.
- R5: A base pulse that sees any `busy` bit high while in reduced mode produces `bus_ce` in the next cycle and clears `slow_active`. Every later base pulse passes through until the domain is idle again.
- R6: With `mem_sync` at 1, the reduced mode is never entered. If the block is already in reduced mode, it leaves it at the next base pulse in the same way as for R5.
- R7: An `extra_div` value of 0 or 1 means no further division. Reduced mode is neither entered nor kept with such a value.
- R8: While `rst` is high, and in the cycle after it falls, `bus_ce` and `slow_active` are 0. The period counter is cleared, so the first reduced period after reset is a full D base pulses long.
- R9: `bus_ce` is high only in a cycle that directly follows a cycle with `base_ce` high.
- R10: `slow_active` is a registered flag that reads 1 exactly while the block is in reduced mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| base_ce | input | 1 | Undivided enable pulse of the bus domain |
| busy | input | N_CLIENTS | Per-client activity flags, 1 = busy |
| extra_div | input | DIV_W | Extra divide applied while idle |
| mem_sync | input | 1 | 1 = memory clock synchronous with bus clock, throttle blocked |
| thr_enable | input | 1 | 1 = throttle feature allowed |
| bus_ce | output | 1 | Registered enable for the bus domain |
| slow_active | output | 1 | Registered flag, 1 = reduced rate in effect |

## Verification
Both outputs are registered, so every result of a base pulse is due in the cycle after the edge that samples it. That holds for a passed or swallowed `bus_ce`, for entering or leaving reduced mode, and for the blocking effect of `busy` and `mem_sync`. The bench drives inputs on the falling edge. A behavioural model, written with integers, updates on the rising edge, and the two outputs are compared with the model on every falling edge, which falls inside the cycle where each result is due. On top of that, the spacing between successive `bus_ce` pulses in steady reduced mode is measured in clock cycles and checked against D times the base pulse spacing.

// File: rtl/bus_idle_throttle_pkg.sv
package bus_idle_throttle_pkg;
  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_SLOW = 1'b1
  } thr_mode_t;
endpackage

// File: rtl/bus_idle_qualify.sv
module bus_idle_qualify #(
  parameter int N_CLIENTS = 4,
  parameter int DIV_W     = 5
) (
  input  logic [N_CLIENTS-1:0] busy,
  input  logic [DIV_W-1:0]     extra_div,
  input  logic                 mem_sync,
  input  logic                 thr_enable,
  output logic                 may_slow
);
  localparam logic [DIV_W-1:0] MinDiv = DIV_W'(2);

  logic all_idle;
  logic div_ok;

  assign all_idle = ~(|busy);
  assign div_ok   = (extra_div >= MinDiv);
  // Synchronous memory mode must keep the rate fixed.
  assign may_slow = thr_enable & ~mem_sync & all_idle & div_ok;
endmodule

// File: rtl/bus_period_ctr.sv
module bus_period_ctr #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             advance,
  input  logic [DIV_W-1:0] div_in,
  output logic             at_end
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;

  assign at_end = (cnt_q == (div_q - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      div_q <= div_in;
    end else if (advance) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bus_idle_throttle.sv
module bus_idle_throttle
  import bus_idle_throttle_pkg::*;
#(
  parameter int N_CLIENTS = 4,
  parameter int DIV_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 base_ce,
  input  logic [N_CLIENTS-1:0] busy,
  input  logic [DIV_W-1:0]     extra_div,
  input  logic                 mem_sync,
  input  logic                 thr_enable,
  output logic                 bus_ce,
  output logic                 slow_active
);
  thr_mode_t mode_q, mode_d;
  logic      may_slow;
  logic      at_end;
  logic      ce_d;
  logic      restart;
  logic      advance;

  bus_idle_qualify #(.N_CLIENTS(N_CLIENTS), .DIV_W(DIV_W)) u_qual (
    .busy       (busy),
    .extra_div  (extra_div),
    .mem_sync   (mem_sync),
    .thr_enable (thr_enable),
    .may_slow   (may_slow)
  );

  bus_period_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .advance (advance),
    .div_in  (extra_div),
    .at_end  (at_end)
  );

  always_comb begin
    mode_d  = mode_q;
    ce_d    = 1'b0;
    restart = 1'b0;
    advance = 1'b0;
    if (base_ce) begin
      if (mode_q == MODE_FULL) begin
        ce_d = 1'b1;
        if (may_slow) begin
          mode_d  = MODE_SLOW;
          restart = 1'b1;
        end
      end else if (!may_slow) begin
        ce_d    = 1'b1;
        mode_d  = MODE_FULL;
        restart = 1'b1;
      end else if (at_end) begin
        ce_d    = 1'b1;
        restart = 1'b1;
      end else begin
        advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_FULL;
      bus_ce <= 1'b0;
    end else begin
      mode_q <= mode_d;
      bus_ce <= ce_d;
    end
  end

  assign slow_active = (mode_q == MODE_SLOW);
endmodule

// File: rtl/bus_idle_throttle_chk.sv
module bus_idle_throttle_chk #(
  parameter int N_CLIENTS = 4,
  parameter int DIV_W     = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 base_ce,
  input logic [N_CLIENTS-1:0] busy,
  input logic [DIV_W-1:0]     extra_div,
  input logic                 mem_sync,
  input logic                 thr_enable,
  input logic                 bus_ce,
  input logic                 slow_active
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R8: outputs quiet right after reset
  always_ff @(posedge clk) begin
    if (rst_q) begin
      p_reset_quiet_r8: assert (!bus_ce && !slow_active)
        else $error("R8 outputs not cleared after reset");
    end
  end

  p_busy_full_r5: assert property (@(posedge clk) disable iff (rst)
    (base_ce && (|busy)) |=> (bus_ce && !slow_active));

  p_sync_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (base_ce && mem_sync) |=> (bus_ce && !slow_active));

  p_small_div_r7: assert property (@(posedge clk) disable iff (rst)
    (base_ce && (extra_div < DIV_W'(2))) |=> !slow_active);

  p_ce_follows_base_r9: assert property (@(posedge clk) disable iff (rst)
    !base_ce |=> !bus_ce);

  p_status_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !base_ce |=> $stable(slow_active));

  p_disabled_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (base_ce && !thr_enable) |=> bus_ce);
endmodule

bind bus_idle_throttle bus_idle_throttle_chk #(
  .N_CLIENTS(N_CLIENTS), .DIV_W(DIV_W)
) u_chk (.*);

// File: tb/test_bus_idle_throttle.sv
module test_bus_idle_throttle;
  localparam int NC = 4;
  localparam int DW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          base_ce = 1'b0;
  logic [NC-1:0] busy = '0;
  logic [DW-1:0] extra_div = '0;
  logic          mem_sync = 1'b0;
  logic          thr_enable = 1'b0;
  logic          bus_ce;
  logic          slow_active;

  int  n_checks = 0;
  int  n_fail = 0;
  int  gap = 1;
  int  phase = 0;
  string cur_req = "R8";
  bit  done = 1'b0;

  // reference model state
  bit  e_ce = 0;
  bit  e_slow = 0;
  int  m_cnt = 0;
  int  m_div = 0;

  always #4 clk = ~clk;

  bus_idle_throttle #(.N_CLIENTS(NC), .DIV_W(DW)) i_bus_idle_throttle (
    .clk(clk), .rst(rst), .base_ce(base_ce), .busy(busy),
    .extra_div(extra_div), .mem_sync(mem_sync), .thr_enable(thr_enable),
    .bus_ce(bus_ce), .slow_active(slow_active)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // base pulse generator
  always @(negedge clk) begin
    phase <= phase + 1;
    base_ce <= ((phase % gap) == 0);
  end

  // behavioural model
  always @(posedge clk) begin
    if (rst) begin
      e_ce = 0; e_slow = 0; m_cnt = 0; m_div = 0;
    end else begin
      e_ce = 0;
      if (base_ce) begin
        bit idle_ok;
        idle_ok = thr_enable && !mem_sync && (busy == 0) && (int'(extra_div) >= 2);
        if (!e_slow) begin
          e_ce = 1;
          if (idle_ok) begin e_slow = 1; m_cnt = 0; m_div = int'(extra_div); end
        end else if (!idle_ok) begin
          e_ce = 1; e_slow = 0;
        end else begin
          m_cnt++;
          if (m_cnt == m_div) begin e_ce = 1; m_cnt = 0; m_div = int'(extra_div); end
        end
      end
    end
  end

  // per-cycle comparison (R9, R10 and the scenario requirement)
  always @(negedge clk) begin
    if (!done) begin
      check({cur_req, "/R9 bus_ce"}, int'(bus_ce), int'(e_ce));
      check({cur_req, "/R10 slow_active"}, int'(slow_active), int'(e_slow));
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input string req, input int exp);
    int c;
    @(negedge clk);
    while (!bus_ce) @(negedge clk);
    c = 0;
    do begin @(negedge clk); c++; end while (!bus_ce && c < 1000);
    check(req, c, exp);
  endtask

  initial begin
    run(3);
    check("R8 reset ce", int'(bus_ce), 0);
    check("R8 reset status", int'(slow_active), 0);
    rst = 1'b0;
    run(1);
    check("R8 post-reset status", int'(slow_active), 0);

    cur_req = "R1"; gap = 2; extra_div = 5'd4; thr_enable = 1'b0;
    run(40);
    check("R1 disabled stays full", int'(slow_active), 0);

    cur_req = "R2"; gap = 1; thr_enable = 1'b1;
    run(4);
    check("R2 status up", int'(slow_active), 1);
    cur_req = "R3";
    measure("R3 interval div4", 4);
    measure("R3 interval div4 again", 4);

    cur_req = "R4"; extra_div = 5'd3;
    run(30);
    measure("R4 new interval div3", 3);

    cur_req = "R5"; busy = 4'b0100;
    run(6);
    check("R5 busy full", int'(slow_active), 0);
    measure("R5 full-rate interval", 1);
    busy = '0;
    run(20);

    cur_req = "R6"; mem_sync = 1'b1;
    run(5);
    check("R6 sync exit", int'(slow_active), 0);
    run(20);
    check("R6 sync blocks entry", int'(slow_active), 0);
    mem_sync = 1'b0;
    run(10);

    cur_req = "R7"; extra_div = 5'd1;
    run(20);
    check("R7 div1 no slow", int'(slow_active), 0);
    extra_div = 5'd0;
    run(20);
    check("R7 div0 no slow", int'(slow_active), 0);

    cur_req = "R3"; gap = 3; extra_div = 5'd5;
    run(60);
    measure("R3 interval gap3 div5", 15);

    cur_req = "R8"; rst = 1'b1;
    run(3);
    check("R8 mid reset status", int'(slow_active), 0);
    rst = 1'b0; gap = 1; extra_div = 5'd6;
    run(3);
    measure("R8 first period full after reset", 6);
    run(20);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_checks++; n_fail++;
    done = 1'b1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule